// File: doc/BRIEF.md
# Split-Cache Snoop Response Controller

This block decides and sequences the coherence actions of a processor that keeps its instruction lines and its data lines in separate caches. It keeps a small direct-mapped line-state store for each side: a four-state MESI code for each data line and a single valid bit for each instruction line. Two sources of work reach it. Outside system logic sends inquire cycles, each with a line address and an invalidate qualifier. The cores send access requests: an instruction fetch or a data access, each with its address. When the block finds a miss on its own side, it checks the opposite cache before the access may go to memory.

A data line in the Modified state is never dropped or downgraded until its contents are safe. The block raises a write-back request on its memory-side port and holds it until the acknowledge arrives. The state change that depends on that write-back takes effect in the acknowledge cycle. For an external inquire, an active-low hit-modified output stays low for the whole write-back. Once an access is cleared to go to memory, the block pulses `fill_go`, and `fill_data` tells a data-side access apart from an instruction fetch. A cache hit pulses `acc_hit` and snoops nothing. A debug port loads and reads both stores.

Top module: `snoop_ctl`

## Requirements
- R1: After reset, `busy` is 0, `hitm_n` is 1, `wb_req`, `fill_go` and `acc_hit` are 0, and every line of both stores reads as invalid. Data states are encoded I=00, S=01, E=10, M=11, and an instruction line is valid when its state bit is 1.
- R2: An inquire with the qualifier low leaves a hit data line in E or S in the S state. It leaves an I line, a line with a different tag and the instruction line unchanged.
- R3: An inquire with the qualifier low that hits an M data line requests a write-back and keeps `hitm_n` low in every cycle of that write-back. The line becomes S in the acknowledge cycle.
- R4: An inquire with the qualifier high invalidates a hit data line, writing an M line back first. It also invalidates a hit valid instruction line.
- R5: An instruction fetch that hits a valid instruction line pulses `acc_hit` and leaves the data store alone. On a miss, an M data line with the same tag is written back and invalidated, and then `fill_go` pulses with `fill_data`=0. `hitm_n` stays 1 throughout.
- R6: A data access that hits a non-I data line pulses `acc_hit` and leaves the instruction store alone. On a miss, a matching valid instruction line is invalidated and `fill_go` pulses with `fill_data`=1.
- R7: While a write-back waits for its acknowledge, the data line it serves stays in M.
- R8: `wb_req` stays high and `wb_addr` stays stable until `wb_ack` is sampled. `wb_addr` is the tag and index of the request, with the offset bits zero.
- R9: An inquire wins over a same-cycle data access or fetch. Only one action runs at a time, and a request that arrives while `busy` is high has no effect.
- R10: The qualifier is captured on the accept edge. Changing `inq_inv` later in the action does not change the result.
- R11: An action that needs no write-back ends two edges after the accept edge. `fill_go` and `acc_hit` are single-cycle pulses and never occur together.
- R12: A debug write sets the tag and state of the chosen line (`dbg_sel`=1 selects data), and the debug read port returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inq_req | input | 1 | External inquire strobe |
| inq_addr | input | ADDR_W | Inquire address |
| inq_inv | input | 1 | Invalidate qualifier of the inquire |
| if_req | input | 1 | Instruction fetch request |
| if_addr | input | ADDR_W | Fetch address |
| da_req | input | 1 | Data read/write request |
| da_addr | input | ADDR_W | Data access address |
| busy | output | 1 | An action is in progress; requests ignored |
| hitm_n | output | 1 | Active-low hit-modified for inquires |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | ADDR_W | Line address of the write-back |
| wb_ack | input | 1 | Write-back complete |
| fill_go | output | 1 | Pulse: the missed access may go to memory |
| fill_data | output | 1 | With fill_go: 1 data access, 0 fetch |
| acc_hit | output | 1 | Pulse: the access hit its own cache |
| dbg_we | input | 1 | Debug line write |
| dbg_sel | input | 1 | Debug target: 1 data store, 0 instruction store |
| dbg_idx | input | IDX_W | Debug write index |
| dbg_tag | input | TAG_W | Debug write tag |
| dbg_st | input | 2 | Debug write state (bit 0 for instruction) |
| dbg_ridx | input | IDX_W | Debug read index |
| dbg_d_st | output | 2 | Data line state at dbg_ridx |
| dbg_d_tag | output | TAG_W | Data line tag at dbg_ridx |
| dbg_i_vld | output | 1 | Instruction line valid at dbg_ridx |
| dbg_i_tag | output | TAG_W | Instruction line tag at dbg_ridx |

## Verification
The hardest condition to reach from the ports is a write-back that is still waiting for its acknowledge while other inputs move. In that window the inquire qualifier flips and new fetch and data requests arrive. The bench preloads a Modified line through the debug port and sends an inquire to it. It then holds back `wb_ack` for a chosen number of cycles. During that delay it reads the line through the debug read port every cycle, toggles `inq_inv`, and raises competing requests. The sweeps cover every stored state, tag match and qualifier value, and vary the acknowledge delay.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
   typedef enum logic [1:0] {
      MESI_I = 2'b00,
      MESI_S = 2'b01,
      MESI_E = 2'b10,
      MESI_M = 2'b11
   } mesi_e;

   typedef enum logic [1:0] {
      K_INQ = 2'd0,
      K_IF  = 2'd1,
      K_DA  = 2'd2
   } kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_WB   = 2'd2
   } seq_e;
endpackage

// File: rtl/line_array.sv
module line_array #(
   parameter int IDX_W = 4,
   parameter int TAG_W = 7,
   parameter int SW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             wtag_en,
   input  logic [IDX_W-1:0] widx,
   input  logic [TAG_W-1:0] wtag,
   input  logic [SW-1:0]    wst,
   input  logic [IDX_W-1:0] ra_idx,
   output logic [TAG_W-1:0] ra_tag,
   output logic [SW-1:0]    ra_st,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [TAG_W-1:0] rb_tag,
   output logic [SW-1:0]    rb_st
);
   localparam int LINES = 1 << IDX_W;

   logic [TAG_W-1:0] tag_w [LINES];
   logic [SW-1:0]    st_w  [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [TAG_W-1:0] tag_r;
      logic [SW-1:0]    st_r;
      logic             sel;
      assign sel = we && (widx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_r <= '0;
            st_r  <= '0;
         end else if (sel) begin
            st_r <= wst;
            if (wtag_en) tag_r <= wtag;
         end
      end
      assign tag_w[g] = tag_r;
      assign st_w[g]  = st_r;
   end

   assign ra_tag = tag_w[ra_idx];
   assign ra_st  = st_w[ra_idx];
   assign rb_tag = tag_w[rb_idx];
   assign rb_st  = st_w[rb_idx];
endmodule

// File: rtl/line_hit.sv
module line_hit #(
   parameter int TAG_W = 7,
   parameter int SW    = 2
) (
   input  logic [TAG_W-1:0] stored_tag,
   input  logic [SW-1:0]    stored_st,
   input  logic [TAG_W-1:0] req_tag,
   output logic             hit
);
   // any nonzero state code is a present line for both store flavours
   if (SW == 1) begin : g_bit
      assign hit = stored_st[0] && (stored_tag == req_tag);
   end else begin : g_code
      assign hit = (|stored_st) && (stored_tag == req_tag);
   end
endmodule

// File: rtl/snoop_plan.sv
module snoop_plan
   import snoop_pkg::*;
(
   input  kind_e kind,
   input  logic  inv,
   input  logic  d_hit,
   input  mesi_e d_st,
   input  logic  i_hit,
   output logic  act_wb,
   output logic  act_d_we,
   output mesi_e act_d_st,
   output logic  act_i_inv,
   output logic  act_fill,
   output logic  act_hit,
   output mesi_e ack_d_st,
   output logic  ack_fill
);
   always_comb begin
      act_wb    = 1'b0;
      act_d_we  = 1'b0;
      act_d_st  = MESI_I;
      act_i_inv = 1'b0;
      act_fill  = 1'b0;
      act_hit   = 1'b0;
      ack_d_st  = (kind == K_INQ && !inv) ? MESI_S : MESI_I;
      ack_fill  = (kind == K_IF);
      unique case (kind)
         K_INQ: begin
            act_i_inv = inv && i_hit;
            if (d_hit) begin
               if (d_st == MESI_M) begin
                  act_wb = 1'b1;
               end else begin
                  act_d_we = 1'b1;
                  act_d_st = inv ? MESI_I : MESI_S;
               end
            end
         end
         K_IF: begin
            if (i_hit)                            act_hit  = 1'b1;
            else if (d_hit && d_st == MESI_M)     act_wb   = 1'b1;
            else                                  act_fill = 1'b1;
         end
         default: begin
            if (d_hit) begin
               act_hit = 1'b1;
            end else begin
               act_i_inv = i_hit;
               act_fill  = 1'b1;
            end
         end
      endcase
   end
endmodule

// File: rtl/snoop_ctl.sv
module snoop_ctl
   import snoop_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFFS_W = 5,
   parameter int IDX_W  = 4,
   parameter int TAG_W  = ADDR_W - OFFS_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inq_req,
   input  logic [ADDR_W-1:0] inq_addr,
   input  logic              inq_inv,
   input  logic              if_req,
   input  logic [ADDR_W-1:0] if_addr,
   input  logic              da_req,
   input  logic [ADDR_W-1:0] da_addr,
   output logic              busy,
   output logic              hitm_n,
   output logic              wb_req,
   output logic [ADDR_W-1:0] wb_addr,
   input  logic              wb_ack,
   output logic              fill_go,
   output logic              fill_data,
   output logic              acc_hit,
   input  logic              dbg_we,
   input  logic              dbg_sel,
   input  logic [IDX_W-1:0]  dbg_idx,
   input  logic [TAG_W-1:0]  dbg_tag,
   input  logic [1:0]        dbg_st,
   input  logic [IDX_W-1:0]  dbg_ridx,
   output logic [1:0]        dbg_d_st,
   output logic [TAG_W-1:0]  dbg_d_tag,
   output logic              dbg_i_vld,
   output logic [TAG_W-1:0]  dbg_i_tag
);
   localparam int LINE_W = ADDR_W - OFFS_W;

   initial begin
      assert (IDX_W >= 1 && IDX_W <= 10) else $error("IDX_W out of range");
      assert (OFFS_W >= 1) else $error("OFFS_W must be at least 1");
      assert (TAG_W >= 1 && TAG_W == ADDR_W - OFFS_W - IDX_W)
         else $error("TAG_W inconsistent with ADDR_W, OFFS_W, IDX_W");
   end

   seq_e               st_q;
   kind_e              kind_q;
   logic               inv_q;
   logic [LINE_W-1:0]  line_q;
   logic               fill_q, hit_q;

   logic               idle, take_inq, take_if, take_da;
   logic [LINE_W-1:0]  take_line;
   logic [IDX_W-1:0]   cur_idx;
   logic [TAG_W-1:0]   cur_tag;

   logic [TAG_W-1:0]   d_rd_tag, i_rd_tag;
   logic [1:0]         cur_d_st;
   logic [0:0]         i_rd_st, dbg_i_st;
   logic               d_hit, i_hit;

   logic               act_wb, act_d_we, act_i_inv, act_fill, act_hit, ack_fill;
   mesi_e              act_d_st, ack_d_st;

   logic               d_we_fsm, i_we_fsm;
   logic [1:0]         d_wst_fsm;
   logic               d_we, i_we, d_wtag_en, i_wtag_en;
   logic [1:0]         d_wst;
   logic [0:0]         i_wst;
   logic [IDX_W-1:0]   d_widx, i_widx;

   wire unused_offs = ^{inq_addr[OFFS_W-1:0], if_addr[OFFS_W-1:0], da_addr[OFFS_W-1:0]};

   // request arbitration: inquire, then fetch, then data access
   assign idle     = (st_q == ST_IDLE);
   assign take_inq = idle && inq_req;
   assign take_if  = idle && !inq_req && if_req;
   assign take_da  = idle && !inq_req && !if_req && da_req;

   always_comb begin
      take_line = da_addr[ADDR_W-1:OFFS_W];
      if (take_inq)     take_line = inq_addr[ADDR_W-1:OFFS_W];
      else if (take_if) take_line = if_addr[ADDR_W-1:OFFS_W];
   end

   assign cur_idx = line_q[IDX_W-1:0];
   assign cur_tag = line_q[LINE_W-1:IDX_W];

   line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .SW(2)) u_dstore (
      .clk(clk), .rst_n(rst_n),
      .we(d_we), .wtag_en(d_wtag_en), .widx(d_widx), .wtag(dbg_tag), .wst(d_wst),
      .ra_idx(cur_idx), .ra_tag(d_rd_tag), .ra_st(cur_d_st),
      .rb_idx(dbg_ridx), .rb_tag(dbg_d_tag), .rb_st(dbg_d_st)
   );

   line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .SW(1)) u_istore (
      .clk(clk), .rst_n(rst_n),
      .we(i_we), .wtag_en(i_wtag_en), .widx(i_widx), .wtag(dbg_tag), .wst(i_wst),
      .ra_idx(cur_idx), .ra_tag(i_rd_tag), .ra_st(i_rd_st),
      .rb_idx(dbg_ridx), .rb_tag(dbg_i_tag), .rb_st(dbg_i_st)
   );
   assign dbg_i_vld = dbg_i_st[0];

   line_hit #(.TAG_W(TAG_W), .SW(2)) u_dhit (
      .stored_tag(d_rd_tag), .stored_st(cur_d_st), .req_tag(cur_tag), .hit(d_hit)
   );
   line_hit #(.TAG_W(TAG_W), .SW(1)) u_ihit (
      .stored_tag(i_rd_tag), .stored_st(i_rd_st), .req_tag(cur_tag), .hit(i_hit)
   );

   snoop_plan u_plan (
      .kind(kind_q), .inv(inv_q), .d_hit(d_hit), .d_st(mesi_e'(cur_d_st)), .i_hit(i_hit),
      .act_wb(act_wb), .act_d_we(act_d_we), .act_d_st(act_d_st), .act_i_inv(act_i_inv),
      .act_fill(act_fill), .act_hit(act_hit), .ack_d_st(ack_d_st), .ack_fill(ack_fill)
   );

   // state-store writes: sequencer has priority over the debug port
   assign d_we_fsm  = ((st_q == ST_ACT) && act_d_we) || ((st_q == ST_WB) && wb_ack);
   assign d_wst_fsm = (st_q == ST_WB) ? ack_d_st : act_d_st;
   assign i_we_fsm  = (st_q == ST_ACT) && act_i_inv;

   assign d_we      = d_we_fsm || (dbg_we && dbg_sel);
   assign d_wtag_en = !d_we_fsm;
   assign d_widx    = d_we_fsm ? cur_idx : dbg_idx;
   assign d_wst     = d_we_fsm ? d_wst_fsm : dbg_st;

   assign i_we      = i_we_fsm || (dbg_we && !dbg_sel);
   assign i_wtag_en = !i_we_fsm;
   assign i_widx    = i_we_fsm ? cur_idx : dbg_idx;
   assign i_wst     = i_we_fsm ? 1'b0 : dbg_st[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= K_INQ;
         inv_q  <= 1'b0;
         line_q <= '0;
         fill_q <= 1'b0;
         hit_q  <= 1'b0;
      end else begin
         fill_q <= 1'b0;
         hit_q  <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (take_inq || take_if || take_da) begin
                  st_q   <= ST_ACT;
                  line_q <= take_line;
                  inv_q  <= take_inq && inq_inv;
                  kind_q <= take_inq ? K_INQ : (take_if ? K_IF : K_DA);
               end
            end
            ST_ACT: begin
               st_q   <= act_wb ? ST_WB : ST_IDLE;
               fill_q <= act_fill;
               hit_q  <= act_hit;
            end
            default: begin
               if (wb_ack) begin
                  st_q   <= ST_IDLE;
                  fill_q <= ack_fill;
               end
            end
         endcase
      end
   end

   assign busy      = !idle;
   assign wb_req    = (st_q == ST_WB);
   assign wb_addr   = {line_q, {OFFS_W{1'b0}}};
   assign hitm_n    = !(wb_req && kind_q == K_INQ);
   assign fill_go   = fill_q;
   assign fill_data = (kind_q == K_DA);
   assign acc_hit   = hit_q;
endmodule

// File: rtl/snoop_ctl_chk.sv
module snoop_ctl_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              hitm_n,
   input logic              wb_req,
   input logic              wb_ack,
   input logic [ADDR_W-1:0] wb_addr,
   input logic              fill_go,
   input logic              acc_hit,
   input logic              inv_q,
   input logic [1:0]        cur_d_st
);
   p_hitm_in_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hitm_n |-> wb_req);

   p_wb_line_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> cur_d_st == 2'b11);

   p_wb_line_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && !wb_ack |=> $stable(cur_d_st));

   p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && !wb_ack |=> wb_req && $stable(wb_addr));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wb_req && hitm_n);

   p_inv_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(inv_q));

   p_fill_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fill_go |=> !fill_go);

   p_hit_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_hit |=> !acc_hit);

   p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_go && acc_hit));
endmodule

bind snoop_ctl snoop_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_snoop_ctl.sv
module sim_snoop_ctl;
   localparam int AW = 16, OW = 5, IW = 4, TW = AW - OW - IW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic inq_req = 0, inq_inv = 0, if_req = 0, da_req = 0, wb_ack = 0;
   logic [AW-1:0] inq_addr = '0, if_addr = '0, da_addr = '0;
   logic busy, hitm_n, wb_req, fill_go, fill_data, acc_hit;
   logic [AW-1:0] wb_addr;
   logic dbg_we = 0, dbg_sel = 0;
   logic [IW-1:0] dbg_idx = '0, dbg_ridx = '0;
   logic [TW-1:0] dbg_tag = '0;
   logic [1:0] dbg_st = '0;
   logic [1:0] dbg_d_st;
   logic [TW-1:0] dbg_d_tag, dbg_i_tag;
   logic dbg_i_vld;

   int n_cmp = 0, n_bad = 0;

   // observations of the last action
   bit o_wb, o_fill, o_fdata, o_hit, o_hold_bad;
   int o_hitm, o_wbc, o_cyc;
   logic [AW-1:0] o_wbaddr;
   bit also_da = 0;
   logic [AW-1:0] also_addr = '0;

   always #10 clk = ~clk;

   snoop_ctl #(.ADDR_W(AW), .OFFS_W(OW), .IDX_W(IW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .inq_req(inq_req), .inq_addr(inq_addr), .inq_inv(inq_inv),
      .if_req(if_req), .if_addr(if_addr), .da_req(da_req), .da_addr(da_addr),
      .busy(busy), .hitm_n(hitm_n), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
      .fill_go(fill_go), .fill_data(fill_data), .acc_hit(acc_hit),
      .dbg_we(dbg_we), .dbg_sel(dbg_sel), .dbg_idx(dbg_idx), .dbg_tag(dbg_tag), .dbg_st(dbg_st),
      .dbg_ridx(dbg_ridx), .dbg_d_st(dbg_d_st), .dbg_d_tag(dbg_d_tag),
      .dbg_i_vld(dbg_i_vld), .dbg_i_tag(dbg_i_tag)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic logic [AW-1:0] mk(input int t, input int idx, input int off);
      return {TW'(t), IW'(idx), OW'(off)};
   endfunction

   task automatic dbg_wr(input bit sel, input int idx, input int tag, input int st);
      @(negedge clk);
      dbg_we = 1; dbg_sel = sel; dbg_idx = IW'(idx); dbg_tag = TW'(tag); dbg_st = 2'(st);
      @(negedge clk);
      dbg_we = 0;
   endtask

   task automatic peek(input int idx);
      dbg_ridx = IW'(idx);
      #1;
   endtask

   task automatic run(input int kind, input logic [AW-1:0] a, input bit inv,
                      input int dly, input bit flip, input bit poke);
      int cyc;
      o_wb = 0; o_fill = 0; o_fdata = 0; o_hit = 0; o_hold_bad = 0;
      o_hitm = 0; o_wbc = 0; o_wbaddr = '0;
      @(negedge clk);
      case (kind)
         0: begin inq_req = 1; inq_addr = a; inq_inv = inv; end
         1: begin if_req = 1; if_addr = a; end
         default: begin da_req = 1; da_addr = a; end
      endcase
      if (also_da) begin da_req = 1; da_addr = also_addr; end
      @(negedge clk);
      inq_req = 0; if_req = 0; da_req = 0;
      dbg_ridx = a[OW+IW-1:OW];
      cyc = 1;
      forever begin
         if (fill_go) begin o_fill = 1; o_fdata = fill_data; end
         if (acc_hit) o_hit = 1;
         if (!busy || cyc > 60) break;
         if (wb_req) begin
            o_wbc++; o_wb = 1; o_wbaddr = wb_addr;
            if (!hitm_n) o_hitm++;
            #1;
            if (dbg_d_st != 2'b11) o_hold_bad = 1;
            if (o_wbc == 1 && flip) inq_inv = ~inv;
            if (o_wbc == 1 && poke) begin
               if_req = 1; if_addr = a ^ {1'b1, {(AW-1){1'b0}}};
               da_req = 1; da_addr = a ^ {2'b10, {(AW-2){1'b0}}};
            end
            if (o_wbc == 2) begin if_req = 0; da_req = 0; end
            if (o_wbc > dly) wb_ack = 1;
         end
         @(negedge clk);
         wb_ack = 0;
         cyc++;
      end
      if_req = 0; da_req = 0; inq_inv = 0;
      o_cyc = cyc;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int n;
      n = 0;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(busy == 0, "R1 busy", busy, 0);
      chk(hitm_n == 1, "R1 hitm_n", hitm_n, 1);
      chk(wb_req == 0 && fill_go == 0 && acc_hit == 0, "R1 outputs", wb_req, 0);
      rst_n = 1;
      @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         peek(i);
         chk(dbg_d_st == 2'b00 && dbg_i_vld == 0, "R1 lines invalid", dbg_d_st, 0);
      end
      // R12: debug write and read back
      dbg_wr(1, 7, 7'h5a, 2);
      dbg_wr(0, 7, 7'h33, 1);
      peek(7);
      chk(dbg_d_st == 2 && dbg_d_tag == 7'h5a, "R12 data line", int'(dbg_d_tag), 'h5a);
      chk(dbg_i_vld == 1 && dbg_i_tag == 7'h33, "R12 instr line", int'(dbg_i_tag), 'h33);

      // Inquire sweep: R2 R3 R4 R8 R11
      for (int ds = 0; ds < 4; ds++)
      for (int inv = 0; inv < 2; inv++)
      for (int iv = 0; iv < 2; iv++)
      for (int m = 0; m < 2; m++) begin
         int idx, t, exp_d, exp_i;
         bit dhit, ihit, ewb;
         idx = n % 16; t = (n * 5 + 3) % 128; n++;
         dbg_wr(1, idx, m ? t : t ^ 1, ds);
         dbg_wr(0, idx, m ? t : t ^ 1, iv);
         dhit = m && ds != 0; ihit = m && iv; ewb = dhit && ds == 3;
         exp_d = !dhit ? ds : (inv ? 0 : 1);
         exp_i = (ihit && inv) ? 0 : iv;
         run(0, mk(t, idx, n % 32), inv[0], n % 4, 0, 0);
         chk(o_wb == ewb, "R3/R4 write-back issued", o_wb, ewb);
         if (ewb) begin
            chk(o_hitm == o_wbc, "R3 hitm_n low during write-back", o_hitm, o_wbc);
            chk(o_wbaddr == mk(t, idx, 0), "R8 write-back address", int'(o_wbaddr), int'(mk(t, idx, 0)));
            chk(!o_hold_bad, "R7 line held until ack", o_hold_bad, 0);
         end else begin
            chk(o_cyc == 2, "R11 action length", o_cyc, 2);
         end
         chk(!o_fill && !o_hit, "R2 no fill or hit on inquire", o_fill, 0);
         peek(idx);
         chk(dbg_d_st == 2'(exp_d), inv ? "R4 data state" : "R2 data state", dbg_d_st, exp_d);
         chk(dbg_i_vld == exp_i[0], inv ? "R4 instr state" : "R2 instr state", dbg_i_vld, exp_i);
      end

      // Fetch sweep: R5
      for (int iv = 0; iv < 2; iv++)
      for (int mi = 0; mi < 2; mi++)
      for (int ds = 0; ds < 4; ds++)
      for (int md = 0; md < 2; md++) begin
         int idx, t;
         bit ihit, ewb;
         idx = n % 16; t = (n * 11 + 1) % 128; n++;
         dbg_wr(0, idx, mi ? t : t ^ 1, iv);
         dbg_wr(1, idx, md ? t : t ^ 1, ds);
         ihit = iv && mi; ewb = !ihit && md && ds == 3;
         run(1, mk(t, idx, 0), 0, n % 3, 0, 0);
         chk(o_hit == ihit, "R5 acc_hit", o_hit, ihit);
         chk(o_fill == !ihit, "R5 fill_go", o_fill, !ihit);
         if (o_fill) chk(o_fdata == 0, "R5 fill_data", o_fdata, 0);
         chk(o_wb == ewb, "R5 write-back", o_wb, ewb);
         chk(o_hitm == 0, "R5 hitm_n stays high", o_hitm, 0);
         if (!ewb) chk(o_cyc == 2, "R11 action length", o_cyc, 2);
         peek(idx);
         chk(dbg_d_st == (ewb ? 2'b00 : 2'(ds)), "R5 data state", dbg_d_st, ewb ? 0 : ds);
         chk(dbg_i_vld == iv[0], "R5 instr untouched", dbg_i_vld, iv);
      end

      // Data access sweep: R6
      for (int ds = 0; ds < 4; ds++)
      for (int md = 0; md < 2; md++)
      for (int iv = 0; iv < 2; iv++)
      for (int mi = 0; mi < 2; mi++) begin
         int idx, t, exp_i;
         bit dhit;
         idx = n % 16; t = (n * 13 + 7) % 128; n++;
         dbg_wr(1, idx, md ? t : t ^ 1, ds);
         dbg_wr(0, idx, mi ? t : t ^ 1, iv);
         dhit = md && ds != 0;
         exp_i = (!dhit && mi && iv) ? 0 : iv;
         run(2, mk(t, idx, 9), 0, 0, 0, 0);
         chk(o_hit == dhit, "R6 acc_hit", o_hit, dhit);
         chk(o_fill == !dhit, "R6 fill_go", o_fill, !dhit);
         if (o_fill) chk(o_fdata == 1, "R6 fill_data", o_fdata, 1);
         chk(o_wb == 0, "R6 no write-back", o_wb, 0);
         chk(o_cyc == 2, "R11 action length", o_cyc, 2);
         peek(idx);
         chk(dbg_i_vld == exp_i[0], "R6 instr state", dbg_i_vld, exp_i);
         chk(dbg_d_st == 2'(ds), "R6 data untouched", dbg_d_st, ds);
      end

      // R10: qualifier flipped during write-back has no effect
      dbg_wr(1, 3, 'h11, 3);
      run(0, mk('h11, 3, 0), 0, 3, 1, 0);
      peek(3);
      chk(dbg_d_st == 2'b01, "R10 qualifier held", dbg_d_st, 1);
      dbg_wr(1, 4, 'h12, 3);
      run(0, mk('h12, 4, 0), 1, 2, 1, 0);
      peek(4);
      chk(dbg_d_st == 2'b00, "R10 qualifier held (set)", dbg_d_st, 0);

      // R9: requests during busy are ignored
      dbg_wr(1, 8, 'h21, 3);
      run(0, mk('h21, 8, 0), 0, 4, 0, 1);
      chk(!o_fill && !o_hit, "R9 no action from busy request", o_fill, 0);
      begin
         bit seen;
         seen = 0;
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (fill_go || acc_hit || busy) seen = 1;
         end
         chk(!seen, "R9 busy requests dropped", seen, 0);
      end

      // R9: inquire wins over same-cycle data access
      dbg_wr(0, 5, 9, 1);
      dbg_wr(1, 5, 0, 0);
      dbg_wr(1, 6, 'h40, 2);
      also_da = 1; also_addr = mk(9, 5, 0);
      run(0, mk('h40, 6, 0), 0, 0, 0, 0);
      also_da = 0;
      chk(!o_fill, "R9 data access lost arbitration", o_fill, 0);
      peek(5);
      chk(dbg_i_vld == 1, "R9 instr line untouched", dbg_i_vld, 1);
      peek(6);
      chk(dbg_d_st == 2'b01, "R9 inquire performed", dbg_d_st, 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule